// File: doc/BRIEF.md
# Colour Converter Host Port with Sequence-Unlocked Command Register

This block decodes the four host-visible registers of a colour look-up converter: the pixel mask, the read index, the write index and the data port. It has a 2-bit register select, one-cycle read and write strobes and an 8-bit write bus. Read data is combinational. All register state changes on the rising clock edge that closes the strobe cycle.

A command register is hidden behind the mask address. It has no address of its own. The host reaches it by reading the mask address several times in a row, four times by default. After that, reads and writes at the mask address go to the command register. Any access to one of the other three addresses sends the mask address back to the pixel mask. The three upper command bits are decoded into a colour mode and a byte-latch style for the pixel path.

The palette contents and the pixel path are outside this block. The data port only takes part in the address decode.

Top module: `dac_host_port`

## Requirements
- R1: At reset the port is locked and the consecutive-read count is zero. The pixel mask resets to 8'hFF, the command register to 8'h00, and both index registers to 8'h00.
- R2: While locked, `UNLOCK_READS` (default 4) reads of select 0, with no other access between them, unlock the port. Every one of those reads, the last one included, returns the pixel mask.
- R3: While unlocked, a read of select 0 returns the command register. A write to select 0 stores into the command register and leaves the pixel mask unchanged.
- R4: A read or a write of select 1 (read index), 2 (write index) or 3 (data) locks the port and clears the count. That access itself is served normally.
- R5: While locked, a write to select 0 stores into the pixel mask and resets the count to zero.
- R6: `color_mode` is 2'd0 (palette) when command bit 7 is 0, whatever bit 6 holds. It is 2'd1 (15-bit) when bit 7 is 1 and bit 6 is 0, and 2'd2 (16-bit) when bits 7 and 6 are both 1.
- R7: `two_clk_latch` equals command bit 5: 1 means two pixel clocks per pixel, 0 means latching on both clock edges.
- R8: A write to select 1 or 2 stores the byte, and a read of that select returns it. A read of select 3 returns 8'h00. `rd_data` is 8'h00 whenever no read is being served.
- R9: Cycles with no strobe do not break a run of consecutive mask reads. When both strobes are high in the same cycle, only the write is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 mask/command, 1 read index, 2 write index, 3 data |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| pixel_mask | output | 8 | Current pixel mask register |
| color_mode | output | 2 | 0 palette, 1 15-bit, 2 16-bit |
| two_clk_latch | output | 1 | Byte-latch style from command bit 5 |

## Verification
The assertions assume that each strobe cycle is one complete host access. They also assume that reset is held for at least one edge before the first access. Nothing is assumed about how strobes are spaced, so the properties also cover idle gaps and back-to-back accesses. The stimulus weights mask-address reads heavily, so unlock runs happen often. It mixes in idle cycles, other-address accesses, mask writes and occasional cycles with both strobes high. This reaches both the hidden register and every path that relocks the port.

// File: rtl/dac_port_pkg.sv
package dac_port_pkg;

  localparam int unsigned DW          = 8;
  localparam int unsigned SEL_W       = 2;
  localparam int unsigned CMD_HI_BIT  = 7;
  localparam int unsigned CMD_16_BIT  = 6;
  localparam int unsigned CMD_LAT_BIT = 5;
  localparam logic [DW-1:0] MASK_RST  = 8'hFF;

  typedef enum logic [SEL_W-1:0] {
    SEL_MASK = 2'd0,
    SEL_RIDX = 2'd1,
    SEL_WIDX = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_PAL   = 2'd0,
    MODE_RGB15 = 2'd1,
    MODE_RGB16 = 2'd2
  } color_mode_e;

  function automatic color_mode_e decode_mode(input logic [DW-1:0] cmd);
    if (!cmd[CMD_HI_BIT])     return MODE_PAL;
    else if (cmd[CMD_16_BIT]) return MODE_RGB16;
    else                      return MODE_RGB15;
  endfunction

endpackage

// File: rtl/dac_unlock_seq.sv
module dac_unlock_seq #(
  parameter int unsigned UNLOCK_READS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_rd,
  input  logic mask_wr,
  input  logic other_acc,
  output logic unlocked,
  output logic count_hit,
  output logic relock_evt
);
  localparam int unsigned CNT_W = (UNLOCK_READS > 2) ? $clog2(UNLOCK_READS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UNLOCK_READS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign count_hit  = !unlocked && mask_rd && (cnt_q == LAST);
  assign relock_evt = other_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      unlocked <= 1'b0;
    end else if (other_acc) begin
      cnt_q    <= '0;
      unlocked <= 1'b0;
    end else if (!unlocked) begin
      if (mask_wr)        cnt_q <= '0;
      else if (count_hit) begin
        cnt_q    <= '0;
        unlocked <= 1'b1;
      end else if (mask_rd) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dac_reg_store.sv
module dac_reg_store
  import dac_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic          unlocked,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] ridx_q,
  output logic [DW-1:0] widx_q
);
  logic we_mask, we_cmd, we_ridx, we_widx;

  assign we_mask = wr_en && (sel == SEL_MASK) && !unlocked;
  assign we_cmd  = wr_en && (sel == SEL_MASK) &&  unlocked;
  assign we_ridx = wr_en && (sel == SEL_RIDX);
  assign we_widx = wr_en && (sel == SEL_WIDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      cmd_q  <= '0;
      ridx_q <= '0;
      widx_q <= '0;
    end else begin
      if (we_mask) mask_q <= wdata;
      if (we_cmd)  cmd_q  <= wdata;
      if (we_ridx) ridx_q <= wdata;
      if (we_widx) widx_q <= wdata;
    end
  end
endmodule

// File: rtl/dac_read_mux.sv
module dac_read_mux
  import dac_port_pkg::*;
(
  input  logic             rd_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             unlocked,
  input  logic [DW-1:0]    mask_q,
  input  logic [DW-1:0]    cmd_q,
  input  logic [DW-1:0]    ridx_q,
  input  logic [DW-1:0]    widx_q,
  output logic [DW-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (reg_sel_e'(sel))
        SEL_MASK: rdata = unlocked ? cmd_q : mask_q;
        SEL_RIDX: rdata = ridx_q;
        SEL_WIDX: rdata = widx_q;
        SEL_DATA: rdata = '0;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dac_host_port.sv
module dac_host_port
  import dac_port_pkg::*;
#(
  parameter int unsigned UNLOCK_READS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] pixel_mask,
  output logic [1:0] color_mode,
  output logic       two_clk_latch
);
  logic rd_en, wr_en, mask_rd, mask_wr, other_acc;
  logic unlocked, count_hit, relock_evt;
  logic [DW-1:0] cmd_q, ridx_q, widx_q;

  assign wr_en     = wr_stb;
  assign rd_en     = rd_stb && !wr_stb;
  assign mask_rd   = rd_en && (reg_sel == SEL_MASK);
  assign mask_wr   = wr_en && (reg_sel == SEL_MASK);
  assign other_acc = (rd_en || wr_en) && (reg_sel != SEL_MASK);

  dac_unlock_seq #(.UNLOCK_READS(UNLOCK_READS)) u_seq (
    .clk(clk), .rst_n(rst_n), .mask_rd(mask_rd), .mask_wr(mask_wr),
    .other_acc(other_acc), .unlocked(unlocked), .count_hit(count_hit),
    .relock_evt(relock_evt)
  );

  dac_reg_store u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(reg_sel),
    .unlocked(unlocked), .wdata(wr_data), .mask_q(pixel_mask),
    .cmd_q(cmd_q), .ridx_q(ridx_q), .widx_q(widx_q)
  );

  dac_read_mux u_rmux (
    .rd_en(rd_en), .sel(reg_sel), .unlocked(unlocked), .mask_q(pixel_mask),
    .cmd_q(cmd_q), .ridx_q(ridx_q), .widx_q(widx_q), .rdata(rd_data)
  );

  assign color_mode    = decode_mode(cmd_q);
  assign two_clk_latch = cmd_q[CMD_LAT_BIT];
endmodule

// File: rtl/dac_port_chk.sv
module dac_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic [7:0] rd_data,
  input logic [7:0] pixel_mask,
  input logic [1:0] color_mode,
  input logic       two_clk_latch,
  input logic       unlocked,
  input logic       count_hit,
  input logic       relock_evt
);
  AST_UNLOCK_FROM_MASK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(rd_stb && !wr_stb && reg_sel == 2'd0)); // R2
  AST_HIT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    count_hit |=> unlocked); // R2
  AST_MASK_HELD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_stb && reg_sel == 2'd0) |=> $stable(pixel_mask)); // R3
  AST_OTHER_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    relock_evt |=> !unlocked); // R4
  AST_LOCKED_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(color_mode) && $stable(two_clk_latch))); // R3
  AST_MASK_WRITE_NO_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_stb && reg_sel == 2'd0) |=> !unlocked); // R5
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    color_mode != 2'd3); // R6
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> rd_data == 8'h00); // R8
endmodule

bind dac_host_port dac_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .rd_data(rd_data), .pixel_mask(pixel_mask),
  .color_mode(color_mode), .two_clk_latch(two_clk_latch),
  .unlocked(unlocked), .count_hit(count_hit), .relock_evt(relock_evt)
);

// File: tb/test_dac_host_port.sv
module test_dac_host_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, pixel_mask;
  logic [1:0] color_mode;
  logic two_clk_latch;

  int errors = 0, checks = 0;
  logic [7:0] m_mask, m_cmd, m_ridx, m_widx;
  int m_cnt;
  bit m_unl;
  bit done = 0;

  always #5 clk = ~clk;

  dac_host_port i_dac_host_port (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
    .pixel_mask(pixel_mask), .color_mode(color_mode),
    .two_clk_latch(two_clk_latch)
  );

  function automatic logic [1:0] exp_mode(logic [7:0] c);
    if (c[7] == 1'b0) return 2'd0;
    return c[6] ? 2'd2 : 2'd1;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs();
    chk("R5 mask", pixel_mask, m_mask);
    chk("R6 mode", {6'd0, color_mode}, {6'd0, exp_mode(m_cmd)});
    chk("R7 latch", {7'd0, two_clk_latch}, {7'd0, m_cmd[5]});
  endtask

  task automatic model_rd(logic [1:0] s);
    if (s == 2'd0) begin
      if (!m_unl) begin
        if (m_cnt == 3) begin m_cnt = 0; m_unl = 1; end
        else m_cnt++;
      end
    end else begin m_unl = 0; m_cnt = 0; end
  endtask

  task automatic model_wr(logic [1:0] s, logic [7:0] d);
    case (s)
      2'd0: if (m_unl) m_cmd = d; else begin m_mask = d; m_cnt = 0; end
      2'd1: begin m_ridx = d; m_unl = 0; m_cnt = 0; end
      2'd2: begin m_widx = d; m_unl = 0; m_cnt = 0; end
      default: begin m_unl = 0; m_cnt = 0; end
    endcase
  endtask

  function automatic logic [7:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0: return m_unl ? m_cmd : m_mask;
      2'd1: return m_ridx;
      2'd2: return m_widx;
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_rd(logic [1:0] s, string req);
    @(negedge clk);
    reg_sel = s; rd_stb = 1; wr_stb = 0;
    #1 chk(req, rd_data, exp_rd(s));
    model_rd(s);
    @(negedge clk); rd_stb = 0;
    #1 chk("R8 idle", rd_data, 8'h00);
  endtask

  task automatic do_wr(logic [1:0] s, logic [7:0] d, bit both);
    @(negedge clk);
    reg_sel = s; wr_data = d; wr_stb = 1; rd_stb = both;
    model_wr(s, d);
    @(negedge clk); wr_stb = 0; rd_stb = 0;
    #1 chk_outs();
  endtask

  task automatic unlock();
    for (int i = 0; i < 4; i++) do_rd(2'd0, "R2 unlock read returns mask");
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_mask = 8'hFF; m_cmd = 8'h00; m_ridx = 0; m_widx = 0; m_cnt = 0; m_unl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 mask", pixel_mask, 8'hFF);
    chk("R1 mode", {6'd0, color_mode}, 8'h00);
    chk("R1 latch", {7'd0, two_clk_latch}, 8'h00);
    do_rd(2'd0, "R1 locked read");
    do_rd(2'd1, "R1 ridx");
    do_rd(2'd2, "R1 widx");
    // R2 unlock; R3 command access
    do_wr(2'd0, 8'h3C, 0);
    unlock();
    do_rd(2'd0, "R3 cmd read");
    do_wr(2'd0, 8'hA0, 0);
    chk("R3 mask kept", pixel_mask, 8'h3C);
    chk("R7 two-clk", {7'd0, two_clk_latch}, 8'h01);
    do_rd(2'd0, "R3 cmd readback");
    // R6 mode combinations
    do_wr(2'd0, 8'h40, 0);
    do_wr(2'd0, 8'hC0, 0);
    chk("R6 16-bit", {6'd0, color_mode}, 8'h02);
    do_wr(2'd0, 8'h80, 0);
    chk("R6 15-bit", {6'd0, color_mode}, 8'h01);
    // R4 relock via read of write-index
    do_rd(2'd2, "R4 widx read");
    do_rd(2'd0, "R4 relocked mask");
    // R5 mask write resets count
    do_rd(2'd0, "R5 r"); do_rd(2'd0, "R5 r"); do_rd(2'd0, "R5 r");
    do_wr(2'd0, 8'h55, 0);
    do_rd(2'd0, "R5 count cleared");
    // R9 idle gaps and both strobes
    do_rd(2'd0, "R9 r");
    repeat (3) @(negedge clk);
    do_rd(2'd0, "R9 r");
    do_rd(2'd0, "R9 r");
    do_rd(2'd0, "R9 unlocked after gaps");
    do_wr(2'd0, 8'h20, 1);
    do_rd(2'd0, "R9 both strobes write only");
    // R8 index and data
    do_wr(2'd1, 8'h12, 0);
    do_wr(2'd2, 8'h34, 0);
    do_rd(2'd1, "R8 ridx");
    do_rd(2'd3, "R8 data");
    do_rd(2'd2, "R8 widx");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 55) do_rd(2'd0, "R2/R3 random mask read");
      else if (r < 65) do_rd(2'($urandom % 4), "R4/R8 random read");
      else if (r < 80) do_wr(2'd0, 8'($urandom), ($urandom % 10) == 0);
      else if (r < 90) do_wr(2'($urandom % 4), 8'($urandom), 0);
      else repeat ($urandom % 3 + 1) @(negedge clk);
      if (n % 16 == 0) begin #1 chk_outs(); end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule